// File: doc/BRIEF.md
# I2C Master Byte-Count and End-of-Transfer Controller

This block sits beside the bus engine of an I2C master. It keeps the number of bytes still to be moved in the current segment, counts it down on every byte-done strobe from the engine, and at terminal count picks one of three endings. It can ask for a STOP on its own. It can hold SCL low and flag that the transfer is complete so that software decides what comes next. It can also hold SCL low and flag that a fresh count is needed, so that a long transfer runs as a chain of segments of up to 255 bytes each.

Configuration arrives through one register write port that carries the whole control word: byte count, auto-end, reload, a PEC-byte request and a START request. Each accepted write is absorbed over a fixed number of cycles. While one is in flight, the port reports not-ready and a second write waits. The PEC-byte request is sticky. Software can only set it, and hardware events clear it. It marks the final byte of a segment as the PEC slot unless reload is on.

Top module: `i2c_len_ctrl`

## Requirements
- R1: After reset the byte count, auto-end, reload, START-pending, PEC request, all flags, `stop_req`, `scl_hold` and `cnt_err` are 0, and `wr_ready` is 1.
- R2: A write is accepted on a clock edge where `wr_en` and `wr_ready` are both 1. Its fields take effect WR_LAT (default 2) edges later. `wr_ready` is 0 from the accept edge until the commit edge, and a write held on `wr_en` in that time is accepted only after `wr_ready` returns to 1.
- R3: A `byte_done` strobe lowers the count by one while the count is non-zero, SCL is not held and the block is in master mode. At count 0 the strobe changes nothing.
- R4: When reload is 0 and auto-end is 1, the byte that brings the count to 0 raises `stop_req` for exactly one cycle, and SCL is not held.
- R5: When reload and auto-end are both 0, that byte sets `tc_flag` and `scl_hold`. Further strobes are ignored while SCL is held.
- R6: When reload is 1, that byte sets `tcr_flag` and `scl_hold` and does not raise `stop_req`, whatever auto-end holds.
- R7: A committed write while `tcr_flag` is 1 loads the new count, clears `tcr_flag` and releases `scl_hold`.
- R8: Writing 1 to the PEC field sets `pec_req`. Writing 0 leaves it unchanged.
- R9: `pec_req` is cleared by `pec_done`, `stop_det`, `addr_match`, or `enable` at 0. Clearing wins over a write that sets it in the same cycle.
- R10: `pec_slot` is 1 only when `pec_req` is 1, reload is 0 and the count is 1.
- R11: A committed write while `start_pend` is 1 leaves the count unchanged and sets the sticky `cnt_err`. `cnt_err` clears when `enable` goes to 0.
- R12: While `slave_mode` is 1, committed writes leave the count, auto-end and reload unchanged, and `byte_done` does not count.
- R13: A committed write with the START field at 1 sets `start_pend`, clears `tc_flag` and releases an SCL hold caused by it. `start_done` clears `start_pend`. `enable` at 0 clears `start_pend`, `tc_flag`, `tcr_flag` and `scl_hold`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Peripheral enable |
| slave_mode | input | 1 | 1 while the peripheral acts as a slave |
| wr_en | input | 1 | Register write request |
| wr_cnt | input | CNT_W | Byte count field of the write |
| wr_auto_end | input | 1 | Auto-end field of the write |
| wr_reload | input | 1 | Reload field of the write |
| wr_pec | input | 1 | PEC-byte request field (set only) |
| wr_start | input | 1 | START request field |
| wr_ready | output | 1 | 1 when a new write can be accepted |
| byte_done | input | 1 | One-cycle strobe per byte moved on the bus |
| start_done | input | 1 | Bus engine has issued the START |
| pec_done | input | 1 | PEC byte has been transferred |
| stop_det | input | 1 | STOP condition seen on the bus |
| addr_match | input | 1 | Own address matched |
| cnt_left | output | CNT_W | Bytes still to move in this segment |
| auto_end | output | 1 | Current auto-end setting |
| reload_on | output | 1 | Current reload setting |
| start_pend | output | 1 | START requested and not yet issued |
| pec_req | output | 1 | Sticky PEC-byte request |
| pec_slot | output | 1 | Next byte is the PEC byte |
| scl_hold | output | 1 | Hold SCL low |
| tc_flag | output | 1 | Transfer complete, waiting for software |
| tcr_flag | output | 1 | Segment done, waiting for a new count |
| stop_req | output | 1 | One-cycle request for a STOP |
| cnt_err | output | 1 | Count write refused while START pending |

## Verification
Every result is registered, so a strobe on `byte_done`, `start_done`, `pec_done`, `stop_det`, `addr_match` or a change of `enable` shows up at the first edge after it is driven. A register write shows up WR_LAT edges after its accept edge, and `wr_ready` drops at the accept edge itself. The bench drives every input on a falling edge. Its driver task counts those edges and pushes an expected snapshot of all outputs into a queue at the falling edge where the result is due. The monitor compares the queue entries a little after each falling edge, which catches `stop_req` within its single high cycle and confirms it is low one cycle later.

// File: rtl/i2c_len_pkg.sv
package i2c_len_pkg;

  // Control bits carried by one register write besides the byte count
  typedef struct packed {
    logic start;
    logic pec;
    logic reload;
    logic auto_end;
  } ctl_t;

endpackage

// File: rtl/len_wr_port.sv
// Accepts a register write, keeps it for WR_LAT cycles, then presents
// it for one cycle as a commit. Further writes wait on wr_ready.
module len_wr_port
  import i2c_len_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int WR_LAT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_cnt,
  input  ctl_t             wr_ctl,
  output logic             wr_ready,
  output logic             cm_valid,
  output logic [CNT_W-1:0] cm_cnt,
  output ctl_t             cm_ctl
);

  localparam int BW = $clog2(WR_LAT + 1);

  logic [BW-1:0]    busy_q;
  logic [CNT_W-1:0] cnt_q;
  ctl_t             ctl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= '0;
      cnt_q  <= '0;
      ctl_q  <= '0;
    end else if (busy_q == '0) begin
      if (wr_en) begin
        busy_q <= BW'(WR_LAT);
        cnt_q  <= wr_cnt;
        ctl_q  <= wr_ctl;
      end
    end else begin
      busy_q <= busy_q - 1'b1;
    end
  end

  assign wr_ready = (busy_q == '0);
  assign cm_valid = (busy_q == BW'(1));
  assign cm_cnt   = cnt_q;
  assign cm_ctl   = ctl_q;

  // R2: an accepted write makes the port busy on the next cycle
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_ready) |=> !wr_ready);

  // R2: after the commit cycle the port is ready again
  a_r2_ready_after_commit: assert property (@(posedge clk) disable iff (rst)
    cm_valid |=> wr_ready);

endmodule

// File: rtl/len_counter.sv
// Byte countdown, end-of-count decision, SCL hold and the flags.
module len_counter
  import i2c_len_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             slave_mode,
  input  logic             cm_valid,
  input  logic [CNT_W-1:0] cm_cnt,
  input  ctl_t             cm_ctl,
  input  logic             byte_done,
  input  logic             start_done,
  output logic [CNT_W-1:0] cnt_q,
  output logic             auto_q,
  output logic             reload_q,
  output logic             start_q,
  output logic             hold_q,
  output logic             tc_q,
  output logic             tcr_q,
  output logic             stop_q,
  output logic             err_q
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

  logic [CNT_W-1:0] cnt_n;
  logic             auto_n, reload_n, start_n, hold_n, tc_n, tcr_n, stop_n, err_n;
  logic             count_ok;

  assign count_ok = enable && byte_done && !hold_q && !slave_mode && (cnt_q != '0);

  always_comb begin
    cnt_n    = cnt_q;
    auto_n   = auto_q;
    reload_n = reload_q;
    start_n  = start_q;
    hold_n   = hold_q;
    tc_n     = tc_q;
    tcr_n    = tcr_q;
    err_n    = err_q;
    stop_n   = 1'b0;

    if (cm_valid && !slave_mode) begin
      auto_n   = cm_ctl.auto_end;
      reload_n = cm_ctl.reload;
    end

    if (!enable) begin
      start_n = 1'b0;
      hold_n  = 1'b0;
      tc_n    = 1'b0;
      tcr_n   = 1'b0;
      err_n   = 1'b0;
      if (cm_valid && !slave_mode) cnt_n = cm_cnt;
    end else begin
      if (start_done) start_n = 1'b0;

      if (count_ok) begin
        cnt_n = cnt_q - 1'b1;
        if (cnt_q == LAST) begin
          if (reload_q) begin
            tcr_n  = 1'b1;
            hold_n = 1'b1;
          end else if (auto_q) begin
            stop_n = 1'b1;
          end else begin
            tc_n   = 1'b1;
            hold_n = 1'b1;
          end
        end
      end

      if (cm_valid) begin
        if (!slave_mode) begin
          if (start_q) begin
            err_n = 1'b1;
          end else begin
            cnt_n = cm_cnt;
            if (tcr_n) begin
              tcr_n  = 1'b0;
              hold_n = tc_n;
            end
          end
        end
        if (cm_ctl.start) begin
          start_n = 1'b1;
          tc_n    = 1'b0;
          hold_n  = tcr_n;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      auto_q   <= 1'b0;
      reload_q <= 1'b0;
      start_q  <= 1'b0;
      hold_q   <= 1'b0;
      tc_q     <= 1'b0;
      tcr_q    <= 1'b0;
      stop_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      cnt_q    <= cnt_n;
      auto_q   <= auto_n;
      reload_q <= reload_n;
      start_q  <= start_n;
      hold_q   <= hold_n;
      tc_q     <= tc_n;
      tcr_q    <= tcr_n;
      stop_q   <= stop_n;
      err_q    <= err_n;
    end
  end

  // R3: a counted byte lowers the count by exactly one
  a_r3_decrement: assert property (@(posedge clk) disable iff (rst)
    (count_ok && !cm_valid) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));

  // R4: the STOP request lasts a single cycle
  a_r4_stop_pulse: assert property (@(posedge clk) disable iff (rst)
    stop_q |=> !stop_q);

  // R5: transfer complete always comes with SCL held
  a_r5_tc_holds: assert property (@(posedge clk) disable iff (rst)
    tc_q |-> hold_q);

  // R6: a reload request always comes with SCL held and never with complete
  a_r6_tcr_holds: assert property (@(posedge clk) disable iff (rst)
    tcr_q |-> (hold_q && !tc_q));

  // R11: a write landing while START is pending raises the error flag
  a_r11_blocked_write: assert property (@(posedge clk) disable iff (rst)
    (cm_valid && start_q && enable && !slave_mode) |=> err_q);

  // R12: the count is frozen in slave mode
  a_r12_slave_frozen: assert property (@(posedge clk) disable iff (rst)
    slave_mode |=> $stable(cnt_q));

endmodule

// File: rtl/len_pec_track.sv
// Sticky PEC-byte request: set by software, cleared by hardware events.
module len_pec_track #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             set_req,
  input  logic             pec_done,
  input  logic             stop_det,
  input  logic             addr_match,
  input  logic             reload_q,
  input  logic [CNT_W-1:0] cnt_q,
  output logic             pec_q,
  output logic             pec_slot
);

  logic clr;
  assign clr = !enable || pec_done || stop_det || addr_match;

  always_ff @(posedge clk) begin
    if (rst)          pec_q <= 1'b0;
    else if (clr)     pec_q <= 1'b0;
    else if (set_req) pec_q <= 1'b1;
  end

  assign pec_slot = pec_q && !reload_q && (cnt_q == CNT_W'(1));

  // R9: any hardware clear event empties the request
  a_r9_hw_clear: assert property (@(posedge clk) disable iff (rst)
    (!enable || pec_done || stop_det || addr_match) |=> !pec_q);

  // R8: without a clear event the request is never dropped
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    (pec_q && enable && !pec_done && !stop_det && !addr_match) |=> pec_q);

endmodule

// File: rtl/i2c_len_ctrl.sv
module i2c_len_ctrl
  import i2c_len_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int WR_LAT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             slave_mode,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic             wr_auto_end,
  input  logic             wr_reload,
  input  logic             wr_pec,
  input  logic             wr_start,
  output logic             wr_ready,
  input  logic             byte_done,
  input  logic             start_done,
  input  logic             pec_done,
  input  logic             stop_det,
  input  logic             addr_match,
  output logic [CNT_W-1:0] cnt_left,
  output logic             auto_end,
  output logic             reload_on,
  output logic             start_pend,
  output logic             pec_req,
  output logic             pec_slot,
  output logic             scl_hold,
  output logic             tc_flag,
  output logic             tcr_flag,
  output logic             stop_req,
  output logic             cnt_err
);

  ctl_t             wr_ctl, cm_ctl;
  logic             cm_valid;
  logic [CNT_W-1:0] cm_cnt;

  assign wr_ctl = '{start: wr_start, pec: wr_pec, reload: wr_reload, auto_end: wr_auto_end};

  len_wr_port #(.CNT_W(CNT_W), .WR_LAT(WR_LAT)) u_port (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_cnt   (wr_cnt),
    .wr_ctl   (wr_ctl),
    .wr_ready (wr_ready),
    .cm_valid (cm_valid),
    .cm_cnt   (cm_cnt),
    .cm_ctl   (cm_ctl)
  );

  len_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .slave_mode (slave_mode),
    .cm_valid   (cm_valid),
    .cm_cnt     (cm_cnt),
    .cm_ctl     (cm_ctl),
    .byte_done  (byte_done),
    .start_done (start_done),
    .cnt_q      (cnt_left),
    .auto_q     (auto_end),
    .reload_q   (reload_on),
    .start_q    (start_pend),
    .hold_q     (scl_hold),
    .tc_q       (tc_flag),
    .tcr_q      (tcr_flag),
    .stop_q     (stop_req),
    .err_q      (cnt_err)
  );

  len_pec_track #(.CNT_W(CNT_W)) u_pec (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .set_req    (cm_valid && cm_ctl.pec),
    .pec_done   (pec_done),
    .stop_det   (stop_det),
    .addr_match (addr_match),
    .reload_q   (reload_on),
    .cnt_q      (cnt_left),
    .pec_q      (pec_req),
    .pec_slot   (pec_slot)
  );

endmodule

// File: tb/sim_i2c_len_ctrl.sv
module sim_i2c_len_ctrl;

  localparam int CNT_W  = 8;
  localparam int WR_LAT = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b1, slave_mode = 1'b0;
  logic wr_en = 1'b0, wr_auto_end = 1'b0, wr_reload = 1'b0, wr_pec = 1'b0, wr_start = 1'b0;
  logic [CNT_W-1:0] wr_cnt = '0;
  logic byte_done = 1'b0, start_done = 1'b0, pec_done = 1'b0, stop_det = 1'b0, addr_match = 1'b0;
  logic wr_ready, auto_end, reload_on, start_pend, pec_req, pec_slot;
  logic scl_hold, tc_flag, tcr_flag, stop_req, cnt_err;
  logic [CNT_W-1:0] cnt_left;

  always #10 clk = ~clk;

  i2c_len_ctrl #(.CNT_W(CNT_W), .WR_LAT(WR_LAT)) u0 (.*);

  typedef struct {
    string           tag;
    logic [CNT_W+10:0] v;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  // Model of the requirements
  logic [CNT_W-1:0] m_cnt = '0;
  bit m_auto, m_reload, m_start, m_pec, m_hold, m_tc, m_tcr, m_stop, m_err;
  bit m_en = 1'b1, m_slave = 1'b0;

  function automatic void chk(string tag, bit rdy);
    item_t it;
    it.tag = tag;
    it.v = {m_cnt, m_auto, m_reload, m_start, m_pec,
            (m_pec && !m_reload && m_cnt == CNT_W'(1)),
            m_hold, m_tc, m_tcr, m_stop, m_err, rdy};
    q.push_back(it);
  endfunction

  // Monitor: compares queued expectations shortly after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0) begin
        item_t it;
        logic [CNT_W+10:0] act;
        it  = q.pop_front();
        act = {cnt_left, auto_end, reload_on, start_pend, pec_req, pec_slot,
               scl_hold, tc_flag, tcr_flag, stop_req, cnt_err, wr_ready};
        checks++;
        if (act !== it.v) begin
          errors++;
          $display("FAIL %s: got %h expected %h", it.tag, act, it.v);
        end
      end
    end
  end

  function automatic void apply_write(logic [CNT_W-1:0] c, bit a, bit r, bit p, bit s);
    if (!m_slave) begin
      m_auto = a;
      m_reload = r;
    end
    if (!m_en) begin
      if (!m_slave) m_cnt = c;
    end else begin
      if (!m_slave) begin
        if (m_start) m_err = 1'b1;
        else begin
          m_cnt = c;
          if (m_tcr) begin
            m_tcr = 1'b0;
            m_hold = m_tc;
          end
        end
      end
      if (s) begin
        m_start = 1'b1;
        m_tc = 1'b0;
        m_hold = m_tcr;
      end
      if (p) m_pec = 1'b1;
    end
  endfunction

  task automatic drive_fields(logic [CNT_W-1:0] c, bit a, bit r, bit p, bit s);
    wr_en = 1'b1; wr_cnt = c; wr_auto_end = a; wr_reload = r; wr_pec = p; wr_start = s;
  endtask

  task automatic do_write(string tag, logic [CNT_W-1:0] c, bit a, bit r, bit p, bit s);
    @(negedge clk);
    drive_fields(c, a, r, p, s);
    @(negedge clk);
    wr_en = 1'b0;
    chk({tag, " R2 busy"}, 1'b0);
    repeat (WR_LAT) @(negedge clk);
    apply_write(c, a, r, p, s);
    chk(tag, 1'b1);
  endtask

  task automatic do_byte(string tag);
    @(negedge clk);
    byte_done = 1'b1;
    @(negedge clk);
    byte_done = 1'b0;
    if (m_en && !m_hold && !m_slave && m_cnt != '0) begin
      if (m_cnt == CNT_W'(1)) begin
        if (m_reload) begin m_tcr = 1'b1; m_hold = 1'b1; end
        else if (m_auto) m_stop = 1'b1;
        else begin m_tc = 1'b1; m_hold = 1'b1; end
      end
      m_cnt = m_cnt - 1'b1;
    end
    chk(tag, 1'b1);
    m_stop = 1'b0;
  endtask

  // ev: 0 start_done, 1 pec_done, 2 stop_det, 3 addr_match
  task automatic do_event(string tag, int ev);
    @(negedge clk);
    case (ev)
      0: start_done = 1'b1;
      1: pec_done = 1'b1;
      2: stop_det = 1'b1;
      default: addr_match = 1'b1;
    endcase
    @(negedge clk);
    start_done = 1'b0; pec_done = 1'b0; stop_det = 1'b0; addr_match = 1'b0;
    if (ev == 0) begin
      if (m_en) m_start = 1'b0;
    end else m_pec = 1'b0;
    chk(tag, 1'b1);
  endtask

  task automatic do_idle(string tag);
    @(negedge clk);
    chk(tag, 1'b1);
  endtask

  task automatic set_en(string tag, bit v);
    @(negedge clk);
    enable = v;
    m_en = v;
    @(negedge clk);
    if (!v) begin
      m_start = 0; m_hold = 0; m_tc = 0; m_tcr = 0; m_err = 0; m_pec = 0;
    end
    chk(tag, 1'b1);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog: got still running expected finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset state", 1'b1);

    // R4: auto-end finishes with a one-cycle STOP request
    do_write("R13 start with auto-end", 8'd3, 1, 0, 0, 1);
    do_event("R13 start_done clears pending", 0);
    do_byte("R3 count 3->2");
    do_byte("R3 count 2->1");
    do_byte("R4 stop request at terminal");
    do_idle("R4 stop request gone");

    // R5: software end holds SCL
    do_write("R13 start soft end", 8'd2, 0, 0, 0, 1);
    do_event("R13 start_done", 0);
    do_byte("R3 count 2->1 soft");
    do_byte("R5 tc and hold");
    do_byte("R5 byte ignored while held");
    do_write("R13 start clears tc", 8'd1, 0, 0, 0, 1);
    do_event("R13 start_done again", 0);

    // R6 / R7: reload mode
    do_write("R6 reload with auto set", 8'd2, 1, 1, 0, 0);
    do_byte("R3 count 2->1 reload");
    do_byte("R6 tcr and hold, no stop");
    do_idle("R6 still waiting");
    do_write("R7 new count releases", 8'd1, 0, 0, 0, 0);
    do_byte("R5 tc after reloaded segment");

    // R11: count write blocked by pending START
    do_write("R13 start with count 4", 8'd4, 0, 0, 0, 1);
    do_write("R11 count refused", 8'd9, 0, 0, 0, 0);
    do_event("R13 start_done clears", 0);

    // R8 / R9 / R10: PEC request
    do_write("R8 R10 pec set slot on", 8'd1, 0, 0, 1, 0);
    do_write("R8 writing 0 keeps pec", 8'd1, 0, 0, 0, 0);
    do_write("R10 reload hides slot", 8'd1, 0, 1, 0, 0);
    do_event("R9 pec_done clears", 1);
    do_write("R8 pec set again", 8'd1, 0, 0, 1, 0);
    do_event("R9 stop_det clears", 2);
    do_write("R8 pec set third", 8'd1, 0, 0, 1, 0);
    do_event("R9 addr_match clears", 3);
    do_write("R8 pec set fourth", 8'd1, 0, 0, 1, 0);
    set_en("R9 R11 R13 enable low clears", 1'b0);
    set_en("R1 enable back", 1'b1);

    // R12: slave mode ignores configuration and bytes
    @(negedge clk);
    slave_mode = 1'b1;
    m_slave = 1'b1;
    do_write("R12 write ignored in slave", 8'd7, 1, 1, 0, 0);
    do_byte("R12 byte ignored in slave");
    @(negedge clk);
    slave_mode = 1'b0;
    m_slave = 1'b0;

    // R2: second write waits for the first
    @(negedge clk);
    drive_fields(8'd5, 0, 0, 0, 0);
    @(negedge clk);
    drive_fields(8'd6, 1, 0, 0, 0);
    chk("R2 first write busy", 1'b0);
    repeat (WR_LAT) @(negedge clk);
    apply_write(8'd5, 0, 0, 0, 0);
    chk("R2 first write committed", 1'b1);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R2 second write accepted late", 1'b0);
    repeat (WR_LAT) @(negedge clk);
    apply_write(8'd6, 1, 0, 0, 0);
    chk("R2 second write committed", 1'b1);

    // R3 boundaries
    do_write("R3 full count", 8'd255, 0, 0, 0, 0);
    do_byte("R3 count 255->254");
    do_write("R3 zero count", 8'd0, 0, 0, 0, 0);
    do_byte("R3 byte at zero ignored");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    finish_run();
  end

endmodule